// File: doc/BRIEF.md
# MicroWire Serial Master Controller

This block is a half-duplex serial master for MicroWire and SPI-style peripherals. Software drives it through seven 16-bit word registers. It loads a transmit word and then writes a command. The command names a chip select, says whether that select is asserted, and gives how many bits to shift out and how many to shift back in. The block then runs the serial clock, shifts the data and raises flags that software polls.

Each of the four chip selects has its own 6-bit setting. The setting chooses the output edge, the sampling edge, the active level of the select line and a post-divider. The serial clock comes from the functional clock through two stages. A shared first stage divides by 2, 4, 7 or 10. The second stage divides by 2, 4 or 8 and belongs to the selected chip select. A separate register inverts the idle level of the serial clock.

Top module: `mw_master`

## Requirements
- R1: Word index 0 takes transmit data on write and returns received data on read. Index 1 is command/status. Indices 2 to 6 are configuration words 1 to 5, which read back as written. After reset every register reads zero, the serial clock pin is low and all four chip-select pins are high.
- R2: Status layout: bit 15 is data ready, bit 14 is busy and bit 13 reads zero. Bit 12 is the select command and bits 11:10 are the select index. Bits 9:5 are the write count and bits 4:0 are the read count, both as last accepted.
- R3: The write phase shifts out write-count bits of the transmit word, starting with bit 15.
- R4: The read phase shifts in read-count bits, right-aligned, and the upper bits read as zero. A count above 16 acts as 16.
- R5: In a chip select's field, bit 0 set samples input on the falling edge and clear samples on the rising edge. Bit 1 set changes output on the rising edge. Bit 1 clear changes output on the falling edge, and in that case the first bit is valid before the first rising edge. Edges refer to the clock before inversion.
- R6: Configuration word 4 bit 0 inverts the serial clock pin, including its idle level.
- R7: Configuration word 3 bits 2:1 select a first-stage ratio of 2, 4, 7 or 10 (codes 0 to 3). Field bits 4:3 select a post-divide of 2, 4 or 8 (codes 0 to 2; code 3 acts as 8). The serial clock period is the product of the two.
- R8: While configuration word 3 bit 0 is clear, a started transfer makes no clock edges and stays busy. It resumes when the bit is set.
- R9: A command with bit 13 set and a nonzero count sets busy from the next cycle until the shift ends. A start with both counts zero is ignored. Any command-word write while busy is ignored entirely.
- R10: Data ready sets when a read phase ends and clears when index 0 is read.
- R11: With both counts nonzero, all write bits go out before the first read bit, under one chip-select assertion.
- R12: Bit 12 asserts the select chosen by bits 11:10, and clearing it deasserts that select. Field bit 2 makes a select active high. The field of the chosen select governs the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ser_clk | output | 1 | Serial clock |
| ser_do | output | 1 | Serial data out |
| ser_di | input | 1 | Serial data in |
| ser_cs | output | 4 | Chip-select pins |

## Verification
The shifter is swept across all four chip selects, all four edge combinations and both clock polarities. The write and read counts vary from 1 to 16 against shifting bit patterns. A peripheral model samples on the edge opposite to the drive edge, so a wrong edge choice or a shift that is one bit off shows up as corrupted data. All twelve ratio and post-divide pairs are checked by measuring the period between rising edges, and the odd ratio 7 separates a correct counter from one that only halves. A combined command, a clamped count, a stalled clock, a command written during busy and active-high selects cover the ordering and the ignore rules.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int DATA_W  = 16;
    localparam int NUM_CS  = 4;
    localparam int CNT_W   = 5;
    localparam int SEL_W   = $clog2(NUM_CS);
    localparam int ADDR_W  = 3;
    localparam int NUM_CFG = 5;
    localparam int FLD_W   = 6;
    localparam int DIV_W   = 4;

    localparam int B_READY = 15;
    localparam int B_BUSY  = 14;
    localparam int B_START = 13;
    localparam int B_CSCMD = 12;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CFG0 = 3'd2;

    typedef struct packed {
        logic       rdy_chk;
        logic [1:0] post;
        logic       cs_hi;
        logic       wr_rise;
        logic       rd_fall;
    } cs_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD} sh_state_t;

    function automatic logic [DIV_W-1:0] div1_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            2'd2:    return 4'd7;
            default: return 4'd10;
        endcase
    endfunction

    function automatic logic [2:0] post_half(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
        return (c > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : c;
    endfunction
endpackage

// File: rtl/mw_clkgen.sv
module mw_clkgen
    import mw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div1_code,
    input  logic [1:0] post_code,
    output logic       htick
);
    logic [DIV_W-1:0] c1_q;
    logic [2:0]       c2_q;
    logic             tick1;
    logic [DIV_W-1:0] ratio;
    logic [2:0]       half;

    assign ratio = div1_ratio(div1_code);
    assign half  = post_half(post_code);
    assign tick1 = run && (c1_q == ratio - 1'b1);
    assign htick = tick1 && (c2_q == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            c1_q <= '0;
            c2_q <= '0;
        end else begin
            c1_q <= tick1 ? '0 : c1_q + 1'b1;
            if (tick1)
                c2_q <= htick ? '0 : c2_q + 1'b1;
        end
    end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
    import mw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_w,
    input  logic [CW-1:0] start_r,
    input  logic          start_wr_rise,
    input  logic          start_rd_fall,
    input  logic [1:0]    start_post,
    input  logic [DW-1:0] tx_word,
    input  logic          htick,
    input  logic          sdi,
    output logic          busy,
    output logic          ph,
    output logic          sdo,
    output logic [1:0]    post_code,
    output logic          rx_done,
    output logic [DW-1:0] rx_data
);
    sh_state_t     state_q;
    logic [CW-1:0] wc_q, rc_q, bit_q;
    logic [DW-1:0] tsh_q, rsh_q, rnext;
    logic          wr_rise_q, rd_fall_q;

    assign busy      = (state_q != ST_IDLE);
    assign rnext     = {rsh_q[DW-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ph        <= 1'b0;
            sdo       <= 1'b0;
            wc_q      <= '0;
            rc_q      <= '0;
            bit_q     <= '0;
            tsh_q     <= '0;
            rsh_q     <= '0;
            wr_rise_q <= 1'b0;
            rd_fall_q <= 1'b0;
            post_code <= '0;
            rx_done   <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        wc_q      <= start_w;
                        rc_q      <= start_r;
                        wr_rise_q <= start_wr_rise;
                        rd_fall_q <= start_rd_fall;
                        post_code <= start_post;
                        bit_q     <= '0;
                        ph        <= 1'b0;
                        rsh_q     <= '0;
                        if (start_w != '0) begin
                            state_q <= ST_WR;
                            if (!start_wr_rise) begin
                                sdo   <= tx_word[DW-1];
                                tsh_q <= tx_word << 1;
                            end else begin
                                tsh_q <= tx_word;
                            end
                        end else begin
                            state_q <= ST_RD;
                        end
                    end
                end
                ST_WR: begin
                    if (htick) begin
                        ph <= ~ph;
                        if (!ph) begin
                            if (wr_rise_q) begin
                                sdo   <= tsh_q[DW-1];
                                tsh_q <= tsh_q << 1;
                            end
                        end else if (bit_q == wc_q - 1'b1) begin
                            bit_q <= '0;
                            rsh_q <= '0;
                            state_q <= (rc_q != '0) ? ST_RD : ST_IDLE;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            if (!wr_rise_q) begin
                                sdo   <= tsh_q[DW-1];
                                tsh_q <= tsh_q << 1;
                            end
                        end
                    end
                end
                ST_RD: begin
                    if (htick) begin
                        ph <= ~ph;
                        if (!ph) begin
                            if (!rd_fall_q)
                                rsh_q <= rnext;
                        end else if (bit_q == rc_q - 1'b1) begin
                            rx_data <= rd_fall_q ? rnext : rsh_q;
                            rx_done <= 1'b1;
                            bit_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            if (rd_fall_q)
                                rsh_q <= rnext;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: the internal clock rests low whenever no shift is in progress
    a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !ph);

    // R9: completing a read leaves the shifter idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> !busy);
endmodule

// File: rtl/mw_regs.sv
module mw_regs
    import mw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NC = NUM_CS,
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             busy,
    input  logic             rx_done,
    input  logic [DW-1:0]    rx_data,
    output logic [DW-1:0]    tx_word,
    output logic             start,
    output logic [CW-1:0]    start_w,
    output logic [CW-1:0]    start_r,
    output cs_cfg_t          start_cfg,
    output logic             clk_en,
    output logic [1:0]       div1_code,
    output logic             cpol,
    output logic             cs_cmd,
    output logic [SEL_W-1:0] cs_sel,
    output logic [NC-1:0]    cs_hi,
    output logic             ready
);
    localparam int PAIRS = NC / 2;

    logic [DW-1:0]    cfg_q [NUM_CFG];
    logic [DW-1:0]    rdr_q;
    logic [CW-1:0]    wcnt_q, rcnt_q;
    cs_cfg_t          cs_cfg [NC];
    logic [DW-1:0]    pair_word [PAIRS];
    logic             cmd_wr;
    logic [CW-1:0]    raw_w, raw_r;
    logic [SEL_W-1:0] new_sel;

    for (genvar i = 0; i < NC; i++) begin : g_fld
        assign cs_cfg[i] = cs_cfg_t'(cfg_q[i/2][FLD_W*(i%2) +: FLD_W]);
        assign cs_hi[i]  = cs_cfg[i].cs_hi;
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_word[p] = {cfg_q[p][DW-1:2*FLD_W], cs_cfg[2*p+1], cs_cfg[2*p]};
    end

    assign raw_w     = wdata[2*CW-1:CW];
    assign raw_r     = wdata[CW-1:0];
    assign new_sel   = wdata[B_CSCMD-1 -: SEL_W];
    assign cmd_wr    = wr && (addr == A_CMD) && !busy;
    assign start     = cmd_wr && wdata[B_START] && ((raw_w != '0) || (raw_r != '0));
    assign start_w   = clamp_cnt(raw_w);
    assign start_r   = clamp_cnt(raw_r);
    assign start_cfg = cs_cfg[new_sel];
    assign clk_en    = cfg_q[2][0];
    assign div1_code = cfg_q[2][2:1];
    assign cpol      = cfg_q[3][0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_CFG; k++) cfg_q[k] <= '0;
            tx_word <= '0;
            rdr_q   <= '0;
            wcnt_q  <= '0;
            rcnt_q  <= '0;
            cs_cmd  <= 1'b0;
            cs_sel  <= '0;
            ready   <= 1'b0;
        end else begin
            if (wr && addr == A_DATA)
                tx_word <= wdata;
            if (cmd_wr) begin
                cs_cmd <= wdata[B_CSCMD];
                cs_sel <= new_sel;
                wcnt_q <= raw_w;
                rcnt_q <= raw_r;
            end
            if (wr && addr >= A_CFG0 && addr < A_CFG0 + AW'(NUM_CFG))
                cfg_q[addr - A_CFG0] <= wdata;
            if (rx_done) begin
                rdr_q <= rx_data;
                ready <= 1'b1;
            end else if (rd && addr == A_DATA) begin
                ready <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA:  rdata = rdr_q;
            A_CMD:   rdata = {ready, busy, 1'b0, cs_cmd, cs_sel, wcnt_q, rcnt_q};
            3'd2:    rdata = pair_word[0];
            3'd3:    rdata = pair_word[1];
            3'd4:    rdata = cfg_q[2];
            3'd5:    rdata = cfg_q[3];
            3'd6:    rdata = cfg_q[4];
            default: rdata = '0;
        endcase
    end

    // R10: a completed read always leaves the ready flag set
    a_r10_ready_set: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> ready);
endmodule

// File: rtl/mw_master.sv
module mw_master
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ser_clk,
    output logic              ser_do,
    input  logic              ser_di,
    output logic [NUM_CS-1:0] ser_cs
);
    logic              busy, ph, htick, rx_done, start, clk_en, cpol, cs_cmd, ready;
    logic [DATA_W-1:0] rx_data, tx_word;
    logic [CNT_W-1:0]  start_w, start_r;
    cs_cfg_t           start_cfg;
    logic [1:0]        div1_code, post_code;
    logic [SEL_W-1:0]  cs_sel;
    logic [NUM_CS-1:0] cs_hi;

    mw_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .rx_done(rx_done),
        .rx_data(rx_data), .tx_word(tx_word), .start(start), .start_w(start_w),
        .start_r(start_r), .start_cfg(start_cfg), .clk_en(clk_en),
        .div1_code(div1_code), .cpol(cpol), .cs_cmd(cs_cmd), .cs_sel(cs_sel),
        .cs_hi(cs_hi), .ready(ready)
    );

    mw_clkgen u_clk (
        .clk(clk), .rst(rst), .run(busy && clk_en), .div1_code(div1_code),
        .post_code(post_code), .htick(htick)
    );

    mw_shifter u_sh (
        .clk(clk), .rst(rst), .start(start), .start_w(start_w), .start_r(start_r),
        .start_wr_rise(start_cfg.wr_rise), .start_rd_fall(start_cfg.rd_fall),
        .start_post(start_cfg.post), .tx_word(tx_word), .htick(htick),
        .sdi(ser_di), .busy(busy), .ph(ph), .sdo(ser_do), .post_code(post_code),
        .rx_done(rx_done), .rx_data(rx_data)
    );

    assign ser_clk = ph ^ cpol;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign ser_cs[i] = (cs_cmd && cs_sel == SEL_W'(i)) ? cs_hi[i] : ~cs_hi[i];
    end

    // R9: an accepted start is visible as busy on the next cycle
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R8: with the controller clock gated off the serial clock holds still
    a_r8_gated_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(ph));
endmodule

// File: tb/mw_master_test.sv
module mw_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ser_clk, ser_do;
    logic        ser_di = 1'b0;
    logic [3:0]  ser_cs;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    bit mon_on = 0, wre_m = 0, red_m = 0, cpol_m = 0;
    int wcnt_m = 0, rcnt_m = 0, rise_i = 0, fall_i = 0, ncap = 0;
    int period = 0, last_rise = 0;
    logic [15:0] rx_pat = '0, cap = '0;
    logic prev_int = 1'b0;

    mw_master uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_clk(ser_clk),
        .ser_do(ser_do), .ser_di(ser_di), .ser_cs(ser_cs)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // peripheral model: drives and samples on the edge opposite the design
    always @(negedge clk) begin
        logic cur;
        cur = ser_clk ^ cpol_m;
        if (mon_on && cur != prev_int) begin
            if (cur) begin
                if (rise_i == 1) period = cyc - last_rise;
                last_rise = cyc;
                if (rise_i < wcnt_m && !wre_m) begin cap = {cap[14:0], ser_do}; ncap++; end
                if (red_m && rise_i >= wcnt_m && rise_i - wcnt_m < rcnt_m)
                    ser_di = rx_pat[rcnt_m - 1 - (rise_i - wcnt_m)];
                rise_i++;
            end else begin
                if (fall_i < wcnt_m && wre_m) begin cap = {cap[14:0], ser_do}; ncap++; end
                if (!red_m && fall_i + 1 >= wcnt_m && fall_i + 1 - wcnt_m < rcnt_m)
                    ser_di = rx_pat[rcnt_m - 1 - (fall_i + 1 - wcnt_m)];
                fall_i++;
            end
        end
        if (mon_on) prev_int = cur;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rreg(input int a, input bit clr, output logic [15:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = clr;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        bus_addr = 3'd1;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            #1;
            if (!bus_rdata[14]) break;
        end
    endtask

    task automatic arm(input int we, input int re, input logic [15:0] rx);
        wcnt_m = we; rcnt_m = re; rx_pat = rx; cap = '0; ncap = 0;
        rise_i = 0; fall_i = 0; prev_int = 1'b0; period = 0;
        if (!red_m && we == 0 && re > 0) ser_di = rx[re-1];
        mon_on = 1;
    endtask

    task automatic xfer(input int cs, input int wc, input int rc,
                        input logic [15:0] tx, input logic [15:0] rx);
        if (wc != 0) wreg(0, tx);
        arm(wc > 16 ? 16 : wc, rc > 16 ? 16 : rc, rx);
        wreg(1, 16'(32'h3000 | (cs << 10) | (wc << 5) | rc));
        wait_idle();
        mon_on = 0;
    endtask

    function automatic int ratio_of(input int c);
        return (c == 0) ? 2 : (c == 1) ? 4 : (c == 2) ? 7 : 10;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rreg(a, 0, d);
            chk($sformatf("R1 reset idx %0d", a), d, 0);
        end
        chk("R1 reset cs pins", ser_cs, 4'hF);
        chk("R1 reset sclk", ser_clk, 0);
        wreg(6, 16'h1234); rreg(6, 0, d); chk("R1 cfg5 readback", d, 16'h1234);
        wreg(2, 16'hF0C5); rreg(2, 0, d); chk("R1 cfg1 readback", d, 16'hF0C5);
        wreg(4, 16'h0001);

        // R3 R4 R5 R6 R10 R12 sweep
        for (int it = 0; it < 32; it++) begin
            int cs, mode, w, r;
            logic [15:0] tx, rx;
            cs = it % 4; mode = (it / 4) % 4;
            w = 1 + ((it * 5) % 16); r = 16 - ((it * 7) % 16);
            tx = 16'hA5C3 ^ 16'(it * 16'h1357);
            rx = 16'h6C39 + 16'(it * 16'h0F1F);
            wreg(2 + cs / 2, 16'(mode << (6 * (cs % 2))));
            wreg(5, 16'(it / 16));
            cpol_m = 1'(it / 16); wre_m = mode[1]; red_m = mode[0];
            chk($sformatf("R6 idle sclk it %0d", it), ser_clk, cpol_m);
            xfer(cs, w, 0, tx, 16'h0);
            chk($sformatf("R3,R5 tx bits it %0d", it), cap, tx >> (16 - w));
            chk($sformatf("R3 tx count it %0d", it), ncap, w);
            chk($sformatf("R12 cs pins it %0d", it), ser_cs, ~(4'b1 << cs) & 4'hF);
            xfer(cs, 0, r, 16'h0, rx);
            rreg(1, 0, d); chk($sformatf("R10 ready set it %0d", it), d[15], 1);
            rreg(0, 1, d);
            chk($sformatf("R4,R5 rx it %0d", it), d, rx & 16'((32'h1 << r) - 1));
            rreg(1, 0, d); chk($sformatf("R10 ready cleared it %0d", it), d[15], 0);
        end

        // R11 combined phase, R2 status layout
        wreg(2, 16'h0); wreg(5, 16'h0); cpol_m = 0; wre_m = 0; red_m = 0;
        xfer(1, 12, 9, 16'hC3A5, 16'h0155);
        chk("R11 tx part", cap, 16'hC3A5 >> 4);
        chk("R11 edges total", rise_i, 21);
        rreg(1, 0, d); chk("R2 status word", d, 16'h9589);
        rreg(0, 1, d); chk("R11 rx part", d, 16'h0155);

        // R4 clamp of count above 16
        xfer(0, 0, 20, 16'h0, 16'hBEEF);
        rreg(0, 1, d); chk("R4 clamp rx", d, 16'hBEEF);
        chk("R4 clamp edges", rise_i, 16);

        // R7 divider sweep
        for (int dv = 0; dv < 4; dv++) begin
            for (int p = 0; p < 4; p++) begin
                int half;
                half = (p == 0) ? 1 : (p == 1) ? 2 : 4;
                wreg(2, 16'(p << 3));
                wreg(4, 16'((dv << 1) | 1));
                xfer(0, 3, 0, 16'hA000, 16'h0);
                chk($sformatf("R7 period div %0d post %0d", dv, p), period,
                    2 * half * ratio_of(dv));
            end
        end

        // R9 busy window, ignored command and zero-count start
        wreg(2, 16'h0); wreg(4, 16'h0007);
        wreg(0, 16'h5A00);
        arm(8, 0, 16'h0);
        wreg(1, 16'h3000 | (8 << 5));
        #1 chk("R9 busy after start", bus_rdata[14], 1);
        wreg(1, 16'h3000 | (3 << 10) | (2 << 5));
        wait_idle(); mon_on = 0;
        chk("R9 ignored start count", ncap, 8);
        chk("R9 first command data", cap, 16'h5A);
        rreg(1, 0, d); chk("R9 ignored command fields", d[11:0], 12'h100);
        wreg(1, 16'h3000);
        #1 chk("R9 zero counts no busy", bus_rdata[14], 0);

        // R8 clock gating stall
        wreg(4, 16'h0000);
        wreg(0, 16'h9000);
        arm(4, 0, 16'h0);
        wreg(1, 16'h3000 | (4 << 5));
        repeat (60) @(negedge clk);
        #1 chk("R8 stalled busy", bus_rdata[14], 1);
        chk("R8 no edges", rise_i, 0);
        wreg(4, 16'h0001);
        wait_idle(); mon_on = 0;
        chk("R8 resumed data", cap, 16'h9);

        // R12 select levels and deassert
        wreg(3, 16'h0004);
        wreg(1, 16'h1000 | (2 << 10)); chk("R12 cs2 active high", ser_cs, 4'b1111);
        wreg(1, 16'h0000 | (2 << 10)); chk("R12 cs2 released", ser_cs, 4'b1011);
        wreg(1, 16'h1000 | (1 << 10)); chk("R12 cs1 active low", ser_cs, 4'b1001);

        // R6 inverted idle
        wreg(5, 16'h0001); chk("R6 inverted idle", ser_clk, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule